// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block sits beside a double data rate SDRAM controller and observes every command the controller sends to a four-bank device. For each command it checks the elapsed time since earlier commands against the device's minimum spacing rules. A command that comes too early produces a one-cycle violation pulse, together with a code that names the rule it broke. The monitor also raises a pulse when a bank's row has stayed open past its maximum lifetime. The block drives nothing towards the memory. It is meant for simulation checkers and on-chip debug of controller schedulers.

All limits are given as parameters in picoseconds, or directly in clocks where the rule is clock based. At elaboration they are converted to clock counts at a fixed clock period (default 6 ns), rounding up. Each bank keeps saturating "cycles since" counters for its last activate, its last precharge start, its last write and its last write with auto-precharge. Three device-wide counters track the last write to any bank, the last auto-refresh and the last self-refresh exit.

The command input is an observation port that carries a valid strobe and no ready signal. The monitor accepts a command in every cycle in which `cmd_valid` is high, and it never back-pressures the controller. The violation output is also valid-only: `viol_valid` marks the cycle, and nothing holds it if the consumer is not looking.

Top module: `sdram_cmd_timing_mon`

## Requirements
- R1: A command is taken when `cmd_valid` is high at a rising clock edge. The command codes are 0 activate, 1 read, 2 write, 3 precharge, 4 read with auto-precharge, 5 write with auto-precharge, 6 auto-refresh, 7 self-refresh entry and 8 self-refresh exit. Codes 9 to 15, and any code presented while `cmd_valid` is low, are ignored and change no history.
- R2: `viol_valid` and `viol_code` are registered. They reflect the command sampled at an edge from just after that same edge. When there is no violation, `viol_code` is 0. The violation codes are: 1 activate-to-column, 2 activate-to-auto-precharge-column, 3 minimum row active, 4 activate-to-activate or refresh, 5 precharge period, 6 bank-to-bank activate, 7 write recovery, 8 write-to-read, 9 auto-precharge write recovery, 10 refresh cycle, 11 self-refresh exit to non-read, 12 self-refresh exit to read, 13 maximum row active.
- R3: A read or write needs at least 3 clocks (18 ns) after an activate to the same bank (code 1). A read or write with auto-precharge needs at least 3 clocks (18 ns) after an activate to the same bank (code 2).
- R4: A precharge needs at least 7 clocks (42 ns) after an activate to the same bank (code 3).
- R5: An activate needs at least 10 clocks (60 ns) after an activate to the same bank. An auto-refresh needs 10 clocks after an activate to any bank (code 4).
- R6: An activate needs at least 3 clocks (18 ns) after a precharge start on the same bank. A precharge or a read with auto-precharge starts a precharge. An auto-refresh needs 3 clocks after a precharge start on any bank (code 5).
- R7: An activate needs at least 2 clocks (12 ns) after an activate to any other bank (code 6).
- R8: A precharge needs at least 5 clocks after a write to the same bank: 2 burst clocks plus 3 clocks (15 ns) of recovery (code 7). An activate needs at least 8 clocks after a write with auto-precharge to that bank: 2 burst clocks plus ceil(15/6)+ceil(18/6) = 6 clocks (code 9).
- R9: A read (with or without auto-precharge) needs at least 3 clocks after a write to any bank: 2 burst clocks plus 1 clock (code 8).
- R10: An activate or an auto-refresh needs at least 12 clocks (72 ns) after an auto-refresh (code 10).
- R11: After a self-refresh exit, any other accepted non-read command needs at least 13 clocks (75 ns) (code 11), and a read needs at least 200 clocks (code 12).
- R12: A bank that stays open for more than 11667 clocks (70,000 ns) gets exactly one pulse with code 13. The pulse is visible after the edge that is 11668 clocks after the activate. A precharge 11667 clocks after the activate produces no pulse.
- R13: When several rules fail at once, the lowest code is reported. A violating command still updates the history exactly as a legal one would.
- R14: Reset clears all history. Every bank is then closed and every counter is expired, so the first commands after reset cause no violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_code | input | 4 | Command code (R1) |
| cmd_bank | input | 2 | Target bank of the command |
| viol_valid | output | 1 | One-cycle flag for a broken rule |
| viol_code | output | 4 | Lowest-numbered broken rule, 0 when none (R2) |

## Verification
Every command-related result appears after the same rising edge that samples the command. The bench therefore drives at a falling edge and reads the violation outputs at the next falling edge, half a cycle after the result became valid. Spacings are counted in sampled edges: two commands issued back to back are 1 clock apart, and each idle cycle inserted between them adds one. The open-row timeout is the only result not tied to a command. It is due 11668 edges after the activate, and the bench polls at every falling edge from the activate onwards to confirm that a single pulse arrives exactly there. Each rule is exercised one clock below its limit and again exactly at its limit, with a reset between scenarios so that earlier history cannot leak in.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_ACT = 4'd0,
    CMD_RD  = 4'd1,
    CMD_WR  = 4'd2,
    CMD_PRE = 4'd3,
    CMD_RDA = 4'd4,
    CMD_WRA = 4'd5,
    CMD_REF = 4'd6,
    CMD_SRE = 4'd7,
    CMD_SRX = 4'd8
  } cmd_e;

  localparam logic [3:0] CMD_LAST = 4'd8;

  typedef enum logic [3:0] {
    V_NONE    = 4'd0,
    V_RCD     = 4'd1,
    V_RAP     = 4'd2,
    V_RAS_MIN = 4'd3,
    V_RC      = 4'd4,
    V_RP      = 4'd5,
    V_RRD     = 4'd6,
    V_WR      = 4'd7,
    V_WTR     = 4'd8,
    V_DAL     = 4'd9,
    V_RFC     = 4'd10,
    V_XSNR    = 4'd11,
    V_XSRD    = 4'd12,
    V_RAS_MAX = 4'd13
  } viol_e;

  localparam int NUM_RULES = 13;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_elapsed_timer.sv
module sdram_elapsed_timer #(
  parameter int W   = 8,
  parameter int SAT = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic [W-1:0] elapsed
);
  // Cycles since the last start, saturating. The reset value is "expired".
  always_ff @(posedge clk) begin
    if (!rst_n)                  elapsed <= W'(SAT);
    else if (start)              elapsed <= W'(1);
    else if (elapsed != W'(SAT)) elapsed <= elapsed + 1'b1;
  end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_mon_pkg::*;
#(
  parameter int W          = 16,
  parameter int SAT        = 1000,
  parameter int RAS_MAX_CK = 900
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  cmd_e         cmd,
  output logic [W-1:0] act_el,
  output logic [W-1:0] pre_el,
  output logic [W-1:0] wr_el,
  output logic [W-1:0] wra_el,
  output logic         timeout
);
  logic is_act, is_pre_start, is_wr, is_wra, closes, row_open;

  assign is_act       = sel && (cmd == CMD_ACT);
  assign is_pre_start = sel && (cmd == CMD_PRE || cmd == CMD_RDA);
  assign is_wr        = sel && (cmd == CMD_WR  || cmd == CMD_WRA);
  assign is_wra       = sel && (cmd == CMD_WRA);
  assign closes       = sel && (cmd == CMD_PRE || cmd == CMD_RDA || cmd == CMD_WRA);

  sdram_elapsed_timer #(.W(W), .SAT(SAT)) u_act (
    .clk(clk), .rst_n(rst_n), .start(is_act), .elapsed(act_el));
  sdram_elapsed_timer #(.W(W), .SAT(SAT)) u_pre (
    .clk(clk), .rst_n(rst_n), .start(is_pre_start), .elapsed(pre_el));
  sdram_elapsed_timer #(.W(W), .SAT(SAT)) u_wr (
    .clk(clk), .rst_n(rst_n), .start(is_wr), .elapsed(wr_el));
  sdram_elapsed_timer #(.W(W), .SAT(SAT)) u_wra (
    .clk(clk), .rst_n(rst_n), .start(is_wra), .elapsed(wra_el));

  always_ff @(posedge clk) begin
    if (!rst_n)      row_open <= 1'b0;
    else if (is_act) row_open <= 1'b1;
    else if (closes) row_open <= 1'b0;
  end

  // Fires once: the counter passes this value exactly once before saturating.
  assign timeout = row_open && (act_el == W'(RAS_MAX_CK + 1));
endmodule

// File: rtl/sdram_rule_eval.sv
module sdram_rule_eval
  import sdram_mon_pkg::*;
#(
  parameter int NB        = 4,
  parameter int BANK_W    = 2,
  parameter int W         = 16,
  parameter int RCD_CK    = 3,
  parameter int RAP_CK    = 3,
  parameter int RAS_CK    = 7,
  parameter int RC_CK     = 10,
  parameter int RP_CK     = 3,
  parameter int RRD_CK    = 2,
  parameter int WRPRE_CK  = 5,
  parameter int WTRD_CK   = 3,
  parameter int DALACT_CK = 8,
  parameter int RFC_CK    = 12,
  parameter int XSNR_CK   = 13,
  parameter int XSRD_CK   = 200
) (
  input  logic              cmd_ok,
  input  cmd_e              cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [W-1:0]      act_el [NB],
  input  logic [W-1:0]      pre_el [NB],
  input  logic [W-1:0]      wr_el  [NB],
  input  logic [W-1:0]      wra_el [NB],
  input  logic [NB-1:0]     timeout,
  input  logic [W-1:0]      gwr_el,
  input  logic [W-1:0]      ref_el,
  input  logic [W-1:0]      srx_el,
  output viol_e             code
);
  logic [NUM_RULES:1] hit;
  logic is_act, is_ref, is_pre, is_rd, is_rw, is_rwa;
  logic any_rc, any_rp, other_rrd;

  assign is_act = cmd_ok && (cmd == CMD_ACT);
  assign is_ref = cmd_ok && (cmd == CMD_REF);
  assign is_pre = cmd_ok && (cmd == CMD_PRE);
  assign is_rd  = cmd_ok && (cmd == CMD_RD  || cmd == CMD_RDA);
  assign is_rw  = cmd_ok && (cmd == CMD_RD  || cmd == CMD_WR);
  assign is_rwa = cmd_ok && (cmd == CMD_RDA || cmd == CMD_WRA);

  always_comb begin
    any_rc    = 1'b0;
    any_rp    = 1'b0;
    other_rrd = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (act_el[b] < W'(RC_CK)) any_rc = 1'b1;
      if (pre_el[b] < W'(RP_CK)) any_rp = 1'b1;
      if (BANK_W'(b) != bank && act_el[b] < W'(RRD_CK)) other_rrd = 1'b1;
    end
  end

  always_comb begin
    hit     = '0;
    hit[1]  = is_rw  && (act_el[bank] < W'(RCD_CK));
    hit[2]  = is_rwa && (act_el[bank] < W'(RAP_CK));
    hit[3]  = is_pre && (act_el[bank] < W'(RAS_CK));
    hit[4]  = (is_act && act_el[bank] < W'(RC_CK)) || (is_ref && any_rc);
    hit[5]  = (is_act && pre_el[bank] < W'(RP_CK)) || (is_ref && any_rp);
    hit[6]  = is_act && other_rrd;
    hit[7]  = is_pre && (wr_el[bank] < W'(WRPRE_CK));
    hit[8]  = is_rd  && (gwr_el < W'(WTRD_CK));
    hit[9]  = is_act && (wra_el[bank] < W'(DALACT_CK));
    hit[10] = (is_act || is_ref) && (ref_el < W'(RFC_CK));
    hit[11] = cmd_ok && !is_rd && (srx_el < W'(XSNR_CK));
    hit[12] = is_rd  && (srx_el < W'(XSRD_CK));
    hit[13] = |timeout;
  end

  // Lowest-numbered broken rule wins.
  always_comb begin
    code = V_NONE;
    for (int i = NUM_RULES; i >= 1; i--) begin
      if (hit[i]) code = viol_e'(4'(i));
    end
  end
endmodule

// File: rtl/sdram_cmd_timing_mon.sv
module sdram_cmd_timing_mon
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int TCK_PS       = 6000,
  parameter int T_RAS_PS     = 42000,
  parameter int T_RAS_MAX_PS = 70_000_000,
  parameter int T_RC_PS      = 60000,
  parameter int T_RFC_PS     = 72000,
  parameter int T_RCD_PS     = 18000,
  parameter int T_RP_PS      = 18000,
  parameter int T_RAP_PS     = 18000,
  parameter int T_RRD_PS     = 12000,
  parameter int T_WR_PS      = 15000,
  parameter int T_XSNR_PS    = 75000,
  parameter int WTR_CK       = 1,
  parameter int BURST_CK     = 2,
  parameter int XSRD_CK      = 200,
  localparam int BANK_W      = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_code,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic              viol_valid,
  output logic [3:0]        viol_code
);
  localparam int RAS_CK     = ceil_div(T_RAS_PS, TCK_PS);
  localparam int RAS_MAX_CK = ceil_div(T_RAS_MAX_PS, TCK_PS);
  localparam int RC_CK      = ceil_div(T_RC_PS, TCK_PS);
  localparam int RFC_CK     = ceil_div(T_RFC_PS, TCK_PS);
  localparam int RCD_CK     = ceil_div(T_RCD_PS, TCK_PS);
  localparam int RP_CK      = ceil_div(T_RP_PS, TCK_PS);
  localparam int RAP_CK     = ceil_div(T_RAP_PS, TCK_PS);
  localparam int RRD_CK     = ceil_div(T_RRD_PS, TCK_PS);
  localparam int WR_CK      = ceil_div(T_WR_PS, TCK_PS);
  localparam int XSNR_CK    = ceil_div(T_XSNR_PS, TCK_PS);
  localparam int DAL_CK     = WR_CK + RP_CK;
  localparam int WRPRE_CK   = BURST_CK + WR_CK;
  localparam int WTRD_CK    = BURST_CK + WTR_CK;
  localparam int DALACT_CK  = BURST_CK + DAL_CK;
  localparam int SAT = max2(max2(RAS_MAX_CK + 2, XSRD_CK),
                            max2(max2(RC_CK, RFC_CK), max2(XSNR_CK, DALACT_CK)));
  localparam int CW  = $clog2(SAT + 1);

  logic              cmd_ok;
  cmd_e              cmd;
  logic [CW-1:0]     act_el [NUM_BANKS];
  logic [CW-1:0]     pre_el [NUM_BANKS];
  logic [CW-1:0]     wr_el  [NUM_BANKS];
  logic [CW-1:0]     wra_el [NUM_BANKS];
  logic [NUM_BANKS-1:0] timeout;
  logic [CW-1:0]     gwr_el, ref_el, srx_el;
  viol_e             code_d;

  assign cmd_ok = cmd_valid && (cmd_code <= CMD_LAST);
  assign cmd    = cmd_e'(cmd_code);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_bank_tracker #(.W(CW), .SAT(SAT), .RAS_MAX_CK(RAS_MAX_CK)) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (cmd_ok && (cmd_bank == BANK_W'(b))),
      .cmd     (cmd),
      .act_el  (act_el[b]),
      .pre_el  (pre_el[b]),
      .wr_el   (wr_el[b]),
      .wra_el  (wra_el[b]),
      .timeout (timeout[b])
    );
  end

  sdram_elapsed_timer #(.W(CW), .SAT(SAT)) u_gwr (
    .clk(clk), .rst_n(rst_n),
    .start(cmd_ok && (cmd == CMD_WR || cmd == CMD_WRA)), .elapsed(gwr_el));
  sdram_elapsed_timer #(.W(CW), .SAT(SAT)) u_ref (
    .clk(clk), .rst_n(rst_n),
    .start(cmd_ok && (cmd == CMD_REF)), .elapsed(ref_el));
  sdram_elapsed_timer #(.W(CW), .SAT(SAT)) u_srx (
    .clk(clk), .rst_n(rst_n),
    .start(cmd_ok && (cmd == CMD_SRX)), .elapsed(srx_el));

  sdram_rule_eval #(
    .NB(NUM_BANKS), .BANK_W(BANK_W), .W(CW),
    .RCD_CK(RCD_CK), .RAP_CK(RAP_CK), .RAS_CK(RAS_CK), .RC_CK(RC_CK),
    .RP_CK(RP_CK), .RRD_CK(RRD_CK), .WRPRE_CK(WRPRE_CK), .WTRD_CK(WTRD_CK),
    .DALACT_CK(DALACT_CK), .RFC_CK(RFC_CK), .XSNR_CK(XSNR_CK), .XSRD_CK(XSRD_CK)
  ) u_eval (
    .cmd_ok(cmd_ok), .cmd(cmd), .bank(cmd_bank),
    .act_el(act_el), .pre_el(pre_el), .wr_el(wr_el), .wra_el(wra_el),
    .timeout(timeout), .gwr_el(gwr_el), .ref_el(ref_el), .srx_el(srx_el),
    .code(code_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_code  <= 4'd0;
    end else begin
      viol_valid <= (code_d != V_NONE);
      viol_code  <= code_d;
    end
  end
endmodule

// File: rtl/sdram_cmd_timing_checker.sv
module sdram_cmd_timing_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [3:0] cmd_code,
  input logic [1:0] cmd_bank,
  input logic       viol_valid,
  input logic [3:0] viol_code
);
  // R2: quiet output carries code 0, a pulse carries a defined rule code
  a_r2_quiet_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_valid |-> viol_code == 4'd0);
  a_r2_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> (viol_code >= 4'd1 && viol_code <= 4'd13));

  // R12: a pulse after a cycle with no command can only be the open-row timeout
  a_r12_idle_pulse_is_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && $past(!cmd_valid)) |-> viol_code == 4'd13);

  // R1: an unused code can only coincide with the open-row timeout
  a_r1_unused_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && $past(cmd_valid && cmd_code > 4'd8)) |-> viol_code == 4'd13);

  // R7: activates to two different banks on adjacent cycles are flagged
  a_r7_back_to_back_act: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_valid && cmd_code == 4'd0) && cmd_valid && cmd_code == 4'd0 &&
     cmd_bank != $past(cmd_bank)) |=> viol_valid);

  // R9: a read right after a write is flagged
  a_r9_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_valid && (cmd_code == 4'd2 || cmd_code == 4'd5)) && cmd_valid &&
     (cmd_code == 4'd1 || cmd_code == 4'd4)) |=> viol_valid);

  // R10: two refreshes on adjacent cycles are flagged
  a_r10_refresh_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_valid && cmd_code == 4'd6) && cmd_valid && cmd_code == 4'd6)
    |=> viol_valid);
endmodule

bind sdram_cmd_timing_mon sdram_cmd_timing_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_bank(cmd_bank), .viol_valid(viol_valid), .viol_code(viol_code)
);

// File: tb/sdram_cmd_timing_mon_bench.sv
`timescale 1ns/1ps
module sdram_cmd_timing_mon_bench;
  localparam logic [3:0] ACT = 4'd0, RD = 4'd1, WR = 4'd2, PRE = 4'd3, RDA = 4'd4,
                         WRA = 4'd5, REF = 4'd6, SRX = 4'd8;
  localparam int RAS_MAX = (70000000 + 6000 - 1) / 6000;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [3:0] cmd_code = 4'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic viol_valid;
  logic [3:0] viol_code;
  logic got_v;
  logic [3:0] got_c;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_cmd_timing_mon u_sdram_cmd_timing_mon (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .viol_valid(viol_valid), .viol_code(viol_code));

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic raw(input logic v, input logic [3:0] c, input logic [1:0] b);
    cmd_valid = v; cmd_code = c; cmd_bank = b;
    @(negedge clk);
    got_v = viol_valid; got_c = viol_code;
    cmd_valid = 1'b0;
  endtask

  // Issue a command d clocks after the previous one.
  task automatic at(input int d, input logic [3:0] c, input logic [1:0] b);
    repeat (d - 1) @(negedge clk);
    raw(1'b1, c, b);
  endtask

  task automatic expect_code(input string tag, input logic [3:0] exp);
    checks++;
    if (got_v !== (exp != 4'd0) || got_c !== exp) begin
      errors++;
      $display("FAIL %s: got valid=%0b code=%0d, expected valid=%0b code=%0d",
               tag, got_v, got_c, exp != 4'd0, exp);
    end
  endtask

  task automatic t_reset();
    do_reset(); raw(1'b0, ACT, 0); expect_code("R2 reset outputs", 0);
    raw(1'b1, ACT, 0); at(1, PRE, 1); do_reset();
    raw(1'b1, RD, 0); expect_code("R14 history cleared rcd", 0);
    at(1, PRE, 0); expect_code("R14 history cleared ras", 0);
  endtask

  task automatic t_rcd();
    do_reset(); raw(1'b1, ACT, 0); at(2, RD, 0);  expect_code("R3 rcd early", 1);
    do_reset(); raw(1'b1, ACT, 0); at(3, WR, 0);  expect_code("R3 rcd at limit", 0);
    do_reset(); raw(1'b1, ACT, 1); at(2, RDA, 1); expect_code("R3 rap early", 2);
    do_reset(); raw(1'b1, ACT, 1); at(3, WRA, 1); expect_code("R3 rap at limit", 0);
  endtask

  task automatic t_ras_rc_rp();
    do_reset(); raw(1'b1, ACT, 2); at(6, PRE, 2); expect_code("R4 ras early", 3);
    do_reset(); raw(1'b1, ACT, 2); at(7, PRE, 2); expect_code("R4 ras at limit", 0);
    at(2, ACT, 2); expect_code("R5 rc early", 4);
    do_reset(); raw(1'b1, ACT, 2); at(7, PRE, 2); at(3, ACT, 2);
    expect_code("R5 rc and rp at limit", 0);
    do_reset(); raw(1'b1, ACT, 3); at(5, REF, 0); expect_code("R5 refresh after act", 4);
    do_reset(); raw(1'b1, ACT, 0); at(20, PRE, 0); at(2, ACT, 0);
    expect_code("R6 rp early", 5);
    do_reset(); raw(1'b1, ACT, 0); at(10, RDA, 0); at(2, ACT, 0);
    expect_code("R6 read autoprecharge starts rp", 5);
  endtask

  task automatic t_rrd();
    do_reset(); raw(1'b1, ACT, 0); at(1, ACT, 1); expect_code("R7 rrd early", 6);
    at(2, ACT, 2); expect_code("R7 rrd at limit", 0);
  endtask

  task automatic t_write();
    do_reset(); raw(1'b1, ACT, 0); at(3, WR, 0); at(4, PRE, 0);
    expect_code("R8 write recovery early", 7);
    do_reset(); raw(1'b1, ACT, 0); at(3, WR, 0); at(5, PRE, 0);
    expect_code("R8 write recovery at limit", 0);
    do_reset(); raw(1'b1, ACT, 0); at(3, WRA, 0); at(7, ACT, 0);
    expect_code("R8 dal early", 9);
    do_reset(); raw(1'b1, ACT, 0); at(3, WRA, 0); at(8, ACT, 0);
    expect_code("R8 dal at limit", 0);
    do_reset(); raw(1'b1, ACT, 0); at(3, WR, 0); at(2, RD, 0);
    expect_code("R9 wtr early", 8);
    do_reset(); raw(1'b1, ACT, 0); at(3, WR, 0); at(3, RD, 0);
    expect_code("R9 wtr at limit", 0);
  endtask

  task automatic t_refresh_srx();
    do_reset(); raw(1'b1, REF, 0); at(11, ACT, 0); expect_code("R10 rfc early", 10);
    do_reset(); raw(1'b1, REF, 0); at(12, ACT, 0); expect_code("R10 rfc at limit", 0);
    do_reset(); raw(1'b1, SRX, 0); at(5, ACT, 0);  expect_code("R11 xsnr early", 11);
    do_reset(); raw(1'b1, SRX, 0); at(13, ACT, 0); expect_code("R11 xsnr at limit", 0);
    at(5, RD, 0); expect_code("R11 xsrd early", 12);
    do_reset(); raw(1'b1, SRX, 0); at(13, ACT, 0); at(187, RD, 0);
    expect_code("R11 xsrd at limit", 0);
    do_reset(); raw(1'b1, SRX, 0); at(13, ACT, 1); at(2, RD, 1);
    expect_code("R13 priority rcd over xsrd", 1);
  endtask

  task automatic t_record_ignore();
    do_reset(); raw(1'b1, ACT, 0); at(1, ACT, 0); expect_code("R13 violating act", 4);
    at(2, RD, 0); expect_code("R13 violating act recorded", 1);
    do_reset(); raw(1'b1, ACT, 1); raw(1'b0, ACT, 1); expect_code("R1 invalid strobe", 0);
    raw(1'b1, 4'd9, 1); expect_code("R1 unused code", 0);
    raw(1'b1, RD, 1); expect_code("R1 no history from ignored", 0);
  endtask

  task automatic t_ras_max();
    int first, pulses;
    do_reset(); raw(1'b1, ACT, 2);
    first = 0; pulses = 0;
    for (int n = 1; n <= RAS_MAX + 3; n++) begin
      @(negedge clk);
      if (viol_valid) begin
        pulses++;
        if (first == 0) first = n;
        got_c = viol_code;
      end
    end
    checks++;
    if (pulses != 1 || first != RAS_MAX + 1 || got_c !== 4'd13) begin
      errors++;
      $display("FAIL R12 timeout: got %0d pulses first=%0d code=%0d, expected 1 at %0d code 13",
               pulses, first, got_c, RAS_MAX + 1);
    end
    do_reset(); raw(1'b1, ACT, 2); at(RAS_MAX, PRE, 2);
    expect_code("R12 precharge at max", 0);
    pulses = 0;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      if (viol_valid) pulses++;
    end
    checks++;
    if (pulses != 0) begin
      errors++;
      $display("FAIL R12 closed row: got %0d pulses, expected 0", pulses);
    end
  endtask

  initial begin
    t_reset();
    t_rcd();
    t_ras_rc_rp();
    t_rrd();
    t_write();
    t_refresh_srx();
    t_record_ignore();
    t_ras_max();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule